// File: doc/BRIEF.md
# Phase and Attenuation Update Controller

This block holds the phase-shifter and attenuator control codes for a single transmit/receive channel. A host writes the requested codes into shadow registers through a plain register port. Nothing it writes reaches the control pins until it pulses a load strobe. On that strobe both codes move to the outputs on the same clock edge. The attenuation code driven out is the commanded attenuation plus a signed correction. That correction comes from a table indexed by the shadow phase code and a temperature bin, so retuning phase does not shift the channel's amplitude.

The temperature bin is computed from a temperature input against three programmable edges. A mode bit picks either the single bin the temperature falls in or the truncated mean of that bin's offset and the next bin's offset. A registered lookup stage prepares the correction. A load that arrives while that stage still holds a result for an older key waits until the result is current. The driven codes and the shadow codes can be read back. A sticky flag reports when the readback from the RF device disagrees with the driven codes once a settling window has passed. A warm reset returns the outputs to the safe state and keeps the shadow registers, bin edges and table.

The block has no data stream. The host port, load, table port and readback are plain single-cycle controls and are always accepted, so there is no back-pressure.

Top module: `phase_atten_ctrl`

## Requirements
- R1: Writes to the shadow phase (address 0) or shadow attenuation (address 1) do not change `ps_code` or `att_code` until a load commits them.
- R2: A `load` pulse in cycle c commits both shadow codes on the same edge, at the end of cycle c+1, when the lookup is current.
- R3: The lookup key is the shadow phase, the temperature bin and the mode bit. A load is held one extra cycle when this key changed on the edge before the commit cycle, or when a table write happened in the previous cycle. The commit then uses the finished lookup.
- R4: The committed `att_code` equals the shadow attenuation plus the signed 4-bit table offset stored for (shadow phase, bin). The table is written with `tbl_we`, `tbl_phase`, `tbl_bin` and `tbl_ofs` in two's complement.
- R5: The bin is the number of the three edges (addresses 2, 3, 4; reset values 64, 128, 192) that are less than or equal to `temp`. This gives bins 0 to 3.
- R6: With mode bit 0 at address 5 set, the offset is (offset[bin] + offset[bin+1]) / 2 truncated toward zero. In bin 3 only that bin's offset is used.
- R7: The sum of attenuation and offset saturates at 0 and at 63 instead of wrapping.
- R8: `rd_data` returns the driven phase, driven attenuation, shadow phase or shadow attenuation for `rd_sel` 0, 1, 2 or 3.
- R9: `rb_mismatch` is set when `dev_ps_rb` or `dev_att_rb` differs from the driven codes after 4 clean cycles since reset, warm reset or commit. It stays set until the next commit or warm reset, and either of these clears it.
- R10: `warm_rst` forces phase 0 and attenuation 63 on the next edge and drops any pending load. Shadow codes, edges, mode and table are kept.
- R11: After `rst_n` the outputs are phase 0 and attenuation 63, the shadows hold 0 and 63, the table is zero, the mode is nearest-bin, and `rb_mismatch` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low full reset |
| warm_rst | input | 1 | Synchronous warm reset to the safe output state |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 phase, 1 attenuation, 2 to 4 bin edges, 5 mode |
| wr_data | input | 8 | Register write data |
| tbl_we | input | 1 | Correction table write strobe |
| tbl_phase | input | 6 | Table write phase index |
| tbl_bin | input | 2 | Table write bin index |
| tbl_ofs | input | 4 | Signed offset to store |
| load | input | 1 | Commit strobe |
| temp | input | 8 | Temperature reading |
| rd_sel | input | 2 | Readback select |
| rd_data | output | 6 | Readback value |
| dev_ps_rb | input | 6 | Phase code read back from the device |
| dev_att_rb | input | 6 | Attenuation code read back from the device |
| ps_code | output | 6 | Driven phase-shifter code |
| att_code | output | 6 | Driven attenuator code |
| rb_mismatch | output | 1 | Sticky readback mismatch flag |

## Verification
The hardest situation to reach is a load that lands while the lookup result is stale. That needs the key or the table to change on exactly the edge that registers the load. The stimulus gets there by driving a shadow phase write together with `load` in one cycle, and a table write together with `load` in another. It then samples the outputs once after the normal commit edge, where they must still be old, and once an edge later. The readback window is reached by injecting a readback error inside the four settling cycles and again after them.

// File: rtl/pau_pkg.sv
`timescale 1ns/1ps
package pau_pkg;
  localparam int PAU_CODE_W = 6;
  localparam int PAU_OFS_W  = 4;
  localparam int PAU_NBINS  = 4;
  localparam int PAU_TEMP_W = 8;
  localparam int PAU_SETTLE = 4;

  typedef enum logic [1:0] {
    RD_ACT_PH = 2'd0,
    RD_ACT_AT = 2'd1,
    RD_SH_PH  = 2'd2,
    RD_SH_AT  = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/pau_bin_sel.sv
`timescale 1ns/1ps
module pau_bin_sel #(
  parameter int TEMP_W = 8,
  parameter int NBINS  = 4,
  parameter int BIN_W  = $clog2(NBINS)
) (
  input  logic [TEMP_W-1:0]            temp,
  input  logic [NBINS-2:0][TEMP_W-1:0] edges,
  output logic [BIN_W-1:0]             bin_lo,
  output logic [BIN_W-1:0]             bin_hi
);
  localparam logic [BIN_W-1:0] TOP_BIN = BIN_W'(NBINS - 1);

  // count edges at or below the reading
  always_comb begin
    bin_lo = '0;
    for (int k = 0; k < NBINS - 1; k++) begin
      if (temp >= edges[k]) bin_lo = bin_lo + BIN_W'(1);
    end
  end

  assign bin_hi = (bin_lo == TOP_BIN) ? bin_lo : bin_lo + BIN_W'(1);
endmodule

// File: rtl/pau_comp_lut.sv
`timescale 1ns/1ps
module pau_comp_lut #(
  parameter int CODE_W = 6,
  parameter int OFS_W  = 4,
  parameter int NBINS  = 4,
  parameter int BIN_W  = $clog2(NBINS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tbl_we,
  input  logic [CODE_W-1:0]       tbl_phase,
  input  logic [BIN_W-1:0]        tbl_bin,
  input  logic [OFS_W-1:0]        tbl_ofs,
  input  logic [CODE_W-1:0]       phase,
  input  logic [BIN_W-1:0]        bin_lo,
  input  logic [BIN_W-1:0]        bin_hi,
  input  logic                    interp,
  output logic signed [OFS_W-1:0] ofs_q,
  output logic                    done
);
  localparam int DEPTH = NBINS << CODE_W;
  localparam int KEY_W = CODE_W + BIN_W + 1;

  logic signed [OFS_W-1:0] mem [DEPTH];
  logic signed [OFS_W-1:0] ofs_a, ofs_b, ofs_sel;
  logic signed [OFS_W:0]   pair_sum, pair_adj;
  logic [KEY_W-1:0]        key_now, tag_q;
  logic                    tag_vld, tblwr_q;

  assign key_now = {interp, bin_lo, phase};
  assign ofs_a   = mem[{bin_lo, phase}];
  assign ofs_b   = mem[{bin_hi, phase}];

  // mean of two neighbours, truncated toward zero
  always_comb begin
    pair_sum = {ofs_a[OFS_W-1], ofs_a} + {ofs_b[OFS_W-1], ofs_b};
    pair_adj = pair_sum + {{OFS_W{1'b0}}, pair_sum[OFS_W]};
    ofs_sel  = interp ? pair_adj[OFS_W:1] : ofs_a;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (tbl_we) begin
      mem[{tbl_bin, tbl_phase}] <= tbl_ofs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q   <= '0;
      tag_q   <= '0;
      tag_vld <= 1'b0;
      tblwr_q <= 1'b0;
    end else begin
      ofs_q   <= ofs_sel;
      tag_q   <= key_now;
      tag_vld <= 1'b1;
      tblwr_q <= tbl_we;
    end
  end

  assign done = tag_vld && (tag_q == key_now) && !tblwr_q;

  // R3: a table write leaves the lookup unfinished for a cycle
  p_tbl_stale_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |=> !done);
  // R3: an unchanged key with no table write yields a finished lookup
  p_key_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tbl_we && $stable(key_now)) |=> (tag_q == $past(key_now)));
endmodule

// File: rtl/pau_commit.sv
`timescale 1ns/1ps
module pau_commit #(
  parameter int CODE_W = 6,
  parameter int OFS_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    warm_rst,
  input  logic                    load,
  input  logic                    done,
  input  logic [CODE_W-1:0]       sh_phase,
  input  logic [CODE_W-1:0]       sh_att,
  input  logic signed [OFS_W-1:0] ofs,
  output logic [CODE_W-1:0]       ps_q,
  output logic [CODE_W-1:0]       att_q,
  output logic                    fire
);
  localparam int SUM_W = CODE_W + 2;
  localparam logic [CODE_W-1:0] ATT_MAX = {CODE_W{1'b1}};
  localparam logic signed [SUM_W-1:0] SUM_MAX = SUM_W'((1 << CODE_W) - 1);

  logic                    load_q, pend_q;
  logic signed [SUM_W-1:0] att_sum;
  logic [CODE_W-1:0]       att_sat;

  assign fire = (load_q || pend_q) && done && !warm_rst;

  always_comb begin
    att_sum = $signed({2'b00, sh_att}) + $signed({{(SUM_W-OFS_W){ofs[OFS_W-1]}}, ofs});
    if (att_sum < 0)            att_sat = '0;
    else if (att_sum > SUM_MAX) att_sat = ATT_MAX;
    else                        att_sat = att_sum[CODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= 1'b0;
      pend_q <= 1'b0;
      ps_q   <= '0;
      att_q  <= ATT_MAX;
    end else if (warm_rst) begin
      load_q <= 1'b0;
      pend_q <= 1'b0;
      ps_q   <= '0;
      att_q  <= ATT_MAX;
    end else begin
      load_q <= load;
      pend_q <= (load_q || pend_q) && !done;
      if (fire) begin
        ps_q  <= sh_phase;
        att_q <= att_sat;
      end
    end
  end

  // R1: outputs move only on a commit or a warm reset
  p_no_early_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !warm_rst) |=> ($stable(ps_q) && $stable(att_q)));
  // R3: a load that meets a stale lookup is held
  p_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_q && !done && !warm_rst) |=> $stable(ps_q));
  // R7: a negative sum lands on zero
  p_sat_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && att_sum < 0) |=> (att_q == '0));
  // R10: warm reset gives the safe codes
  p_warm_safe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst |=> (ps_q == '0 && att_q == ATT_MAX));
endmodule

// File: rtl/pau_rb_check.sv
`timescale 1ns/1ps
module pau_rb_check #(
  parameter int CODE_W = 6,
  parameter int SETTLE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst,
  input  logic              fire,
  input  logic [CODE_W-1:0] ps,
  input  logic [CODE_W-1:0] att,
  input  logic [CODE_W-1:0] rb_ps,
  input  logic [CODE_W-1:0] rb_att,
  output logic              mismatch
);
  localparam int CNT_W = $clog2(SETTLE + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(SETTLE);

  logic [CNT_W-1:0] settle_q;
  logic             differs;

  assign differs = (rb_ps != ps) || (rb_att != att);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= '0;
      mismatch <= 1'b0;
    end else if (fire || warm_rst) begin
      settle_q <= '0;
      mismatch <= 1'b0;
    end else if (settle_q != CNT_TOP) begin
      settle_q <= settle_q + CNT_W'(1);
    end else if (differs) begin
      mismatch <= 1'b1;
    end
  end

  // R9: commit or warm reset clears the flag
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire || warm_rst) |=> !mismatch);
  // R9: the flag is sticky
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch && !fire && !warm_rst) |=> mismatch);
  // R9: nothing is flagged inside the settling window
  p_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_q != CNT_TOP && !mismatch) |=> !mismatch);
endmodule

// File: rtl/phase_atten_ctrl.sv
`timescale 1ns/1ps
module phase_atten_ctrl #(
  parameter int CODE_W = pau_pkg::PAU_CODE_W,
  parameter int OFS_W  = pau_pkg::PAU_OFS_W,
  parameter int NBINS  = pau_pkg::PAU_NBINS,
  parameter int TEMP_W = pau_pkg::PAU_TEMP_W,
  parameter int SETTLE = pau_pkg::PAU_SETTLE,
  parameter int BIN_W  = $clog2(NBINS),
  parameter int ADDR_W = $clog2(NBINS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [TEMP_W-1:0] wr_data,
  input  logic              tbl_we,
  input  logic [CODE_W-1:0] tbl_phase,
  input  logic [BIN_W-1:0]  tbl_bin,
  input  logic [OFS_W-1:0]  tbl_ofs,
  input  logic              load,
  input  logic [TEMP_W-1:0] temp,
  input  logic [1:0]        rd_sel,
  output logic [CODE_W-1:0] rd_data,
  input  logic [CODE_W-1:0] dev_ps_rb,
  input  logic [CODE_W-1:0] dev_att_rb,
  output logic [CODE_W-1:0] ps_code,
  output logic [CODE_W-1:0] att_code,
  output logic              rb_mismatch
);
  import pau_pkg::*;

  localparam logic [ADDR_W-1:0] A_PHASE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ATT   = ADDR_W'(1);
  localparam int                EDGE_B  = 2;
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(NBINS + 1);
  localparam int                BIN_SPAN = (1 << TEMP_W) / NBINS;

  logic [CODE_W-1:0]            sh_phase, sh_att;
  logic [NBINS-2:0][TEMP_W-1:0] edge_q;
  logic                         interp_q;
  logic [BIN_W-1:0]             bin_lo, bin_hi;
  logic signed [OFS_W-1:0]      ofs_q;
  logic                         lut_done, fire;

  // shadow registers and configuration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_phase <= '0;
      sh_att   <= {CODE_W{1'b1}};
      interp_q <= 1'b0;
      for (int k = 0; k < NBINS - 1; k++) edge_q[k] <= TEMP_W'((k + 1) * BIN_SPAN);
    end else if (wr_en) begin
      if (wr_addr == A_PHASE) sh_phase <= wr_data[CODE_W-1:0];
      if (wr_addr == A_ATT)   sh_att   <= wr_data[CODE_W-1:0];
      if (wr_addr == A_MODE)  interp_q <= wr_data[0];
      for (int k = 0; k < NBINS - 1; k++) begin
        if (wr_addr == ADDR_W'(k + EDGE_B)) edge_q[k] <= wr_data;
      end
    end
  end

  pau_bin_sel #(.TEMP_W(TEMP_W), .NBINS(NBINS), .BIN_W(BIN_W)) u_bin (
    .temp  (temp),
    .edges (edge_q),
    .bin_lo(bin_lo),
    .bin_hi(bin_hi)
  );

  pau_comp_lut #(.CODE_W(CODE_W), .OFS_W(OFS_W), .NBINS(NBINS), .BIN_W(BIN_W)) u_lut (
    .clk      (clk),
    .rst_n    (rst_n),
    .tbl_we   (tbl_we),
    .tbl_phase(tbl_phase),
    .tbl_bin  (tbl_bin),
    .tbl_ofs  (tbl_ofs),
    .phase    (sh_phase),
    .bin_lo   (bin_lo),
    .bin_hi   (bin_hi),
    .interp   (interp_q),
    .ofs_q    (ofs_q),
    .done     (lut_done)
  );

  pau_commit #(.CODE_W(CODE_W), .OFS_W(OFS_W)) u_commit (
    .clk     (clk),
    .rst_n   (rst_n),
    .warm_rst(warm_rst),
    .load    (load),
    .done    (lut_done),
    .sh_phase(sh_phase),
    .sh_att  (sh_att),
    .ofs     (ofs_q),
    .ps_q    (ps_code),
    .att_q   (att_code),
    .fire    (fire)
  );

  pau_rb_check #(.CODE_W(CODE_W), .SETTLE(SETTLE)) u_rb (
    .clk     (clk),
    .rst_n   (rst_n),
    .warm_rst(warm_rst),
    .fire    (fire),
    .ps      (ps_code),
    .att     (att_code),
    .rb_ps   (dev_ps_rb),
    .rb_att  (dev_att_rb),
    .mismatch(rb_mismatch)
  );

  always_comb begin
    unique case (rd_sel_e'(rd_sel))
      RD_ACT_PH: rd_data = ps_code;
      RD_ACT_AT: rd_data = att_code;
      RD_SH_PH:  rd_data = sh_phase;
      RD_SH_AT:  rd_data = sh_att;
      default:   rd_data = '0;
    endcase
  end

  // R10: warm reset keeps the shadow codes
  p_warm_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_rst && !wr_en) |=> ($stable(sh_phase) && $stable(sh_att)));
  // R2: a commit copies the shadow phase to the pins
  p_commit_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (ps_code == $past(sh_phase)));
endmodule

// File: tb/sim_phase_atten_ctrl.sv
`timescale 1ns/1ps
module sim_phase_atten_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       warm_rst = 1'b0, wr_en = 1'b0, tbl_we = 1'b0, load = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0, temp = 8'd100;
  logic [5:0] tbl_phase = '0;
  logic [1:0] tbl_bin = '0, rd_sel = '0;
  logic [3:0] tbl_ofs = '0;
  logic [5:0] rd_data, ps_code, att_code, dev_ps_rb, dev_att_rb;
  logic [5:0] inj_ps = '0, inj_att = '0;
  logic       rb_mismatch;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  assign dev_ps_rb  = ps_code ^ inj_ps;
  assign dev_att_rb = att_code ^ inj_att;

  phase_atten_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tbl_we(tbl_we), .tbl_phase(tbl_phase), .tbl_bin(tbl_bin),
    .tbl_ofs(tbl_ofs), .load(load), .temp(temp), .rd_sel(rd_sel), .rd_data(rd_data),
    .dev_ps_rb(dev_ps_rb), .dev_att_rb(dev_att_rb), .ps_code(ps_code),
    .att_code(att_code), .rb_mismatch(rb_mismatch)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_tbl [64][4];
  int m_edge [3];
  int m_mode, m_sph, m_sat, m_ps, m_at, m_ldq, m_pend;
  int m_pkey, m_pofs, m_ptw, m_pvld, m_cnt, m_mis;

  function automatic int mbin(input int t);
    int b = 0;
    for (int k = 0; k < 3; k++) if (t >= m_edge[k]) b++;
    return b;
  endfunction

  function automatic int mofs(input int ph, input int b);
    int hb;
    if (m_mode == 0) return m_tbl[ph][b];
    hb = (b == 3) ? b : b + 1;
    return (m_tbl[ph][b] + m_tbl[ph][hb]) / 2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < 64; p++) for (int b = 0; b < 4; b++) m_tbl[p][b] = 0;
      m_edge[0] = 64; m_edge[1] = 128; m_edge[2] = 192;
      m_mode = 0; m_sph = 0; m_sat = 63; m_ps = 0; m_at = 63;
      m_ldq = 0; m_pend = 0; m_pkey = 0; m_pofs = 0; m_ptw = 0; m_pvld = 0;
      m_cnt = 0; m_mis = 0;
    end else begin
      int b, key, ofs_now, done, fire, s;
      b = mbin(int'(temp));
      key = (m_mode << 8) | (b << 6) | m_sph;
      ofs_now = mofs(m_sph, b);
      done = (m_pvld != 0 && m_pkey == key && m_ptw == 0) ? 1 : 0;
      fire = ((m_ldq != 0 || m_pend != 0) && done != 0 && !warm_rst) ? 1 : 0;
      if (fire != 0 || warm_rst) begin m_cnt = 0; m_mis = 0; end
      else if (m_cnt < 4) m_cnt++;
      else if (inj_ps != 0 || inj_att != 0) m_mis = 1;
      if (warm_rst) begin
        m_ps = 0; m_at = 63; m_ldq = 0; m_pend = 0;
      end else begin
        if (fire != 0) begin
          m_ps = m_sph;
          s = m_sat + m_pofs;
          m_at = (s < 0) ? 0 : ((s > 63) ? 63 : s);
        end
        m_pend = ((m_ldq != 0 || m_pend != 0) && done == 0) ? 1 : 0;
        m_ldq = load ? 1 : 0;
      end
      m_pkey = key; m_pofs = ofs_now; m_ptw = tbl_we ? 1 : 0; m_pvld = 1;
      if (tbl_we) m_tbl[tbl_phase][tbl_bin] = int'($signed(tbl_ofs));
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_sph = int'(wr_data[5:0]);
          3'd1: m_sat = int'(wr_data[5:0]);
          3'd2: m_edge[0] = int'(wr_data);
          3'd3: m_edge[1] = int'(wr_data);
          3'd4: m_edge[2] = int'(wr_data);
          3'd5: m_mode = int'(wr_data[0]);
          default: ;
        endcase
      end
    end
  end

  // compare against the model on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 ps_code per-cycle", int'(ps_code), m_ps);
      chk("R4 att_code per-cycle", int'(att_code), m_at);
      chk("R9 rb_mismatch per-cycle", int'(rb_mismatch), m_mis);
    end
  end

  task automatic wreg(input int a, input int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic twr(input int ph, input int b, input int o);
    tbl_we = 1'b1; tbl_phase = 6'(ph); tbl_bin = 2'(b); tbl_ofs = 4'(o);
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic pulse_load();
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input int s, output int v);
    rd_sel = 2'(s);
    #1;
    v = int'(rd_data);
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 ps_code after reset", int'(ps_code), 0);
    chk("R11 att_code after reset", int'(att_code), 63);
    chk("R11 rb_mismatch after reset", int'(rb_mismatch), 0);
    rd(2, v); chk("R11 shadow phase", v, 0);
    rd(3, v); chk("R11 shadow att", v, 63);

    twr(5, 1, -3); twr(5, 2, 6); twr(9, 1, -3); twr(9, 2, -4); twr(9, 3, 2);
    // R1 shadow writes stay off the pins
    wreg(0, 5); wreg(1, 20);
    repeat (3) @(negedge clk);
    chk("R1 ps_code before load", int'(ps_code), 0);
    chk("R1 att_code before load", int'(att_code), 63);
    // R2 and R4 joint commit with offset
    pulse_load();
    chk("R2 ps_code committed", int'(ps_code), 5);
    chk("R4 att_code 20-3", int'(att_code), 17);
    // R5 bin selection
    temp = 8'd130; @(negedge clk); pulse_load();
    chk("R5 bin2 att", int'(att_code), 26);
    temp = 8'd50; @(negedge clk); pulse_load();
    chk("R5 bin0 att", int'(att_code), 20);
    // R6 interpolation
    temp = 8'd100; wreg(5, 1); pulse_load();
    chk("R6 avg(-3,6) att", int'(att_code), 21);
    wreg(0, 9); pulse_load();
    chk("R6 avg(-3,-4) toward zero", int'(att_code), 17);
    temp = 8'd200; @(negedge clk); pulse_load();
    chk("R6 top bin alone", int'(att_code), 22);
    wreg(5, 0);
    // R7 saturation
    temp = 8'd100; wreg(1, 1); pulse_load();
    chk("R7 floor at 0", int'(att_code), 0);
    temp = 8'd130; wreg(0, 5); wreg(1, 60); pulse_load();
    chk("R7 ceiling at 63", int'(att_code), 63);
    // R3 write and load in the same cycle
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'd9; load = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; load = 1'b0;
    @(negedge clk);
    chk("R3 held after phase write", int'(ps_code), 5);
    @(negedge clk);
    chk("R3 ps after hold", int'(ps_code), 9);
    chk("R3 att after hold", int'(att_code), 56);
    // R3 table write and load in the same cycle
    tbl_we = 1'b1; tbl_phase = 6'd9; tbl_bin = 2'd2; tbl_ofs = 4'hF; load = 1'b1;
    @(negedge clk);
    tbl_we = 1'b0; load = 1'b0;
    @(negedge clk);
    chk("R3 held after table write", int'(att_code), 56);
    @(negedge clk);
    chk("R3 fresh offset used", int'(att_code), 59);
    // R9 readback check
    repeat (5) @(negedge clk);
    chk("R9 no mismatch when equal", int'(rb_mismatch), 0);
    inj_ps = 6'd1; @(negedge clk); inj_ps = 6'd0;
    chk("R9 mismatch raised", int'(rb_mismatch), 1);
    repeat (2) @(negedge clk);
    chk("R9 mismatch sticky", int'(rb_mismatch), 1);
    pulse_load();
    chk("R9 cleared by commit", int'(rb_mismatch), 0);
    inj_att = 6'd2;
    repeat (2) @(negedge clk);
    chk("R9 quiet in settle window", int'(rb_mismatch), 0);
    repeat (3) @(negedge clk);
    chk("R9 raised after window", int'(rb_mismatch), 1);
    inj_att = 6'd0;
    // R10 warm reset
    warm_rst = 1'b1; @(negedge clk); warm_rst = 1'b0;
    chk("R10 ps safe", int'(ps_code), 0);
    chk("R10 att safe", int'(att_code), 63);
    chk("R10 mismatch cleared", int'(rb_mismatch), 0);
    rd(2, v); chk("R10 shadow phase kept", v, 9);
    rd(3, v); chk("R10 shadow att kept", v, 60);
    pulse_load();
    chk("R10 table kept att", int'(att_code), 59);
    // R8 readback of driven codes
    rd(0, v); chk("R8 active phase", v, 9);
    rd(1, v); chk("R8 active att", v, 59);
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule